// File: doc/BRIEF.md
# Receive Descriptor Ring Index Controller

This block is the device-side bookkeeping for a ring of receive buffer descriptors that the host keeps in its own memory. Software programs a control word and advances a write index as it hands out empty buffers. The block keeps its own fill index, decides whether a free buffer exists when a frame begins, and closes the current buffer when the frame ends or when a programmable close timer runs out. Each close produces a one-cycle status write-back carrying the index of the buffer just filled, and, if enabled, an interrupt pulse.

The ring length is a power of two chosen by a 4-bit field. A channel control field runs the channel, stops it at once, or lets the current frame finish before it goes quiet. An idle flag tells software when the channel has fully stopped. Fetching descriptors, moving data and modelling memory are done elsewhere. The fill side only sees start and end strobes and the accept or drop answer.

Top module: `rxr_ring_ctrl`

## Requirements
- R1: After reset the control word, write index and fill index are 0, status reads 0x01000000 (idle), and frm_accept, frm_drop, wb_valid and irq are low.
- R2: The ring length is 2^n, where n is control bits 23:20 clamped to the range 5..12. The fill index counts modulo the ring length, so it wraps from length-1 to 0.
- R3: A write to the write index register (address 1) with any of bits 2:0 set is ignored. Otherwise bits 11:0 are stored and read back unchanged.
- R4: A buffer is free when the fill index differs from the write index taken modulo the ring length. A frame start with no free buffer pulses frm_drop for one cycle, one cycle after the strobe.
- R5: A frame start while the channel is running (control bits 31:30 = 2), with no buffer open and a free buffer, pulses frm_accept one cycle later and opens a buffer. Any other start pulses frm_drop, and the two pulses never coincide.
- R6: A frame end while a buffer is open closes it. One cycle later wb_valid pulses with wb_index set to the fill index before the close, and the fill index advances by one.
- R7: irq pulses together with wb_valid only when control bits 13:12 are 1. Values 0, 2 and 3 give no interrupt.
- R8: With a non-zero timeout T in control bits 11:4, an open buffer closes by itself. wb_valid rises T*TICK_CYCLES+1 cycles after the edge that accepted the frame. T = 0 never closes a buffer by time.
- R9: A frame end that arrives in the same cycle as timer expiry produces a single close and a single fill index step.
- R10: Channel value 0 stops the channel at the next clock. An open buffer is discarded with no write-back, and status bit 24 reads 1.
- R11: Channel value 1 drops new starts, lets the open frame close normally with a write-back, and then reports idle.
- R12: Channel value 3 behaves like value 0.
- R13: rb_bytes equals 4096*(s+1), where s is control bits 17:16.
- R14: A frame end with no open buffer has no effect on wb_valid, irq or the fill index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 write index, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| frm_start | input | 1 | Frame begins on the fill side |
| frm_end | input | 1 | Frame completes on the fill side |
| frm_accept | output | 1 | Frame was given a buffer |
| frm_drop | output | 1 | Frame was refused |
| cur_idx | output | 12 | Fill index (next descriptor to fill) |
| wb_valid | output | 1 | Status write-back strobe |
| wb_index | output | 12 | Index of the last filled descriptor |
| irq | output | 1 | Host interrupt pulse |
| rb_bytes | output | 15 | Selected receive buffer size in bytes |
| ch_idle | output | 1 | Channel idle, same as status bit 24 |

## Verification
A frame end and the close timer can both end the same open buffer in the same cycle. The bench opens a frame with a timeout of 3 units of 4 cycles each, counts twelve cycles, and drives the frame end in the exact cycle the timer reaches its limit. It then expects exactly one write-back, with the old index, and no second one in the following cycle. It also expects the next frame to report an index only one step further on. The bench also lets a frame start meet a full ring and a pause request meet an open frame, and judges each at the accept, drop and write-back pins.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        CH_OFF = 2'd0,
        CH_EOF = 2'd1,
        CH_RUN = 2'd2,
        CH_RSV = 2'd3
    } chan_e;

    typedef struct packed {
        chan_e      chan;
        logic [3:0] log_raw;
        logic [1:0] bsize;
        logic [1:0] irqt;
        logic [7:0] tmo;
    } cfg_t;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_WPTR = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] IRQ_HOST = 2'd1;
endpackage

// File: rtl/rxr_regfile.sv
module rxr_regfile
    import rxr_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             idle,
    input  logic [IDX_W-1:0] fill,
    output cfg_t             cfg,
    output logic [IDX_W-1:0] wptr,
    output logic [31:0]      reg_rdata
);
    typedef struct packed {
        cfg_t             cfg;
        logic [IDX_W-1:0] wptr;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (reg_wr && reg_addr == A_CFG) begin
            rf_d.cfg.chan    = chan_e'(reg_wdata[31:30]);
            rf_d.cfg.log_raw = reg_wdata[23:20];
            rf_d.cfg.bsize   = reg_wdata[17:16];
            rf_d.cfg.irqt    = reg_wdata[13:12];
            rf_d.cfg.tmo     = reg_wdata[11:4];
        end
        if (reg_wr && reg_addr == A_WPTR && reg_wdata[2:0] == 3'b000) begin
            rf_d.wptr = reg_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        case (reg_addr)
            A_CFG:   reg_rdata = {rf_q.cfg.chan, 6'b0, rf_q.cfg.log_raw, 2'b0,
                                  rf_q.cfg.bsize, 2'b0, rf_q.cfg.irqt,
                                  rf_q.cfg.tmo, 4'b0};
            A_WPTR:  reg_rdata = 32'(rf_q.wptr);
            A_STAT:  reg_rdata = (32'(idle) << 24) | 32'(fill);
            default: reg_rdata = '0;
        endcase
    end

    assign cfg  = rf_q.cfg;
    assign wptr = rf_q.wptr;

    AST_WPTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.wptr[2:0] == 3'b000); // R3
endmodule

// File: rtl/rxr_ring_geom.sv
module rxr_ring_geom #(
    parameter int IDX_W   = 12,
    parameter int MIN_LOG = 5
) (
    input  logic [3:0]       log_raw,
    input  logic [1:0]       bsize,
    output logic [IDX_W-1:0] mask,
    output logic [14:0]      rb_bytes
);
    logic [3:0] log_eff;

    always_comb begin
        if (int'(log_raw) < MIN_LOG)    log_eff = 4'(MIN_LOG);
        else if (int'(log_raw) > IDX_W) log_eff = 4'(IDX_W);
        else                            log_eff = log_raw;
        for (int i = 0; i < IDX_W; i++) begin
            mask[i] = (i < int'(log_eff));
        end
    end

    assign rb_bytes = (15'(bsize) + 15'd1) << 12;
endmodule

// File: rtl/rxr_close_timer.sv
module rxr_close_timer #(
    parameter int TICK_CYCLES = 1600,
    parameter int TMO_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             running,
    input  logic [TMO_W-1:0] tmo,
    output logic             expire
);
    localparam int PW = $clog2(TICK_CYCLES + 1);
    localparam logic [PW-1:0] PLAST = PW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [PW-1:0]    presc;
        logic [TMO_W-1:0] units;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (restart) begin
            tm_d = '0;
        end else if (running) begin
            if (tm_q.presc == PLAST) begin
                tm_d.presc = '0;
                if (tm_q.units != '1) tm_d.units = tm_q.units + 1'b1;
            end else begin
                tm_d.presc = tm_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expire = running && (tmo != '0) && (tm_q.units == tmo);

    AST_TIMER_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tm_q.units == '0)); // R8
endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl
    import rxr_pkg::*;
#(
    parameter int IDX_W       = 12,
    parameter int MIN_LOG     = 5,
    parameter int TICK_CYCLES = 1600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             frm_start,
    input  logic             frm_end,
    output logic             frm_accept,
    output logic             frm_drop,
    output logic [IDX_W-1:0] cur_idx,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_index,
    output logic             irq,
    output logic [14:0]      rb_bytes,
    output logic             ch_idle
);
    typedef struct packed {
        logic             open;
        logic             accept;
        logic             drop;
        logic             wb_v;
        logic             irq;
        logic [IDX_W-1:0] fill;
        logic [IDX_W-1:0] wb_idx;
    } st_t;

    st_t              st_d, st_q;
    cfg_t             cfg;
    logic [IDX_W-1:0] wptr, mask;
    logic             avail, start_ok, closing, expire, stopped;

    rxr_regfile #(.IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .idle(ch_idle), .fill(st_q.fill),
        .cfg(cfg), .wptr(wptr), .reg_rdata(reg_rdata)
    );

    rxr_ring_geom #(.IDX_W(IDX_W), .MIN_LOG(MIN_LOG)) u_geom (
        .log_raw(cfg.log_raw), .bsize(cfg.bsize), .mask(mask), .rb_bytes(rb_bytes)
    );

    rxr_close_timer #(.TICK_CYCLES(TICK_CYCLES), .TMO_W(8)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(start_ok), .running(st_q.open),
        .tmo(cfg.tmo), .expire(expire)
    );

    assign stopped  = (cfg.chan == CH_OFF) || (cfg.chan == CH_RSV);
    assign avail    = (st_q.fill & mask) != (wptr & mask);
    assign start_ok = frm_start && (cfg.chan == CH_RUN) && !st_q.open && avail;
    assign closing  = st_q.open && !stopped && (frm_end || expire);

    always_comb begin
        st_d        = st_q;
        st_d.accept = start_ok;
        st_d.drop   = frm_start && !start_ok;
        st_d.wb_v   = 1'b0;
        st_d.irq    = 1'b0;
        if (stopped) begin
            st_d.open = 1'b0;
        end else if (closing) begin
            st_d.open   = 1'b0;
            st_d.fill   = (st_q.fill + 1'b1) & mask;
            st_d.wb_v   = 1'b1;
            st_d.wb_idx = st_q.fill & mask;
            st_d.irq    = (cfg.irqt == IRQ_HOST);
        end
        if (start_ok) st_d.open = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_accept = st_q.accept;
    assign frm_drop   = st_q.drop;
    assign cur_idx    = st_q.fill;
    assign wb_valid   = st_q.wb_v;
    assign wb_index   = st_q.wb_idx;
    assign irq        = st_q.irq;
    assign ch_idle    = (cfg.chan != CH_RUN) && !st_q.open;

    AST_ACCEPT_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        frm_accept |-> $past(avail)); // R4
    AST_ACCEPT_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_accept && frm_drop)); // R5
    AST_WB_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(st_q.open)); // R6
    AST_IRQ_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wb_valid); // R7
    AST_STOP_NEXT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> !st_q.open); // R10
endmodule

// File: tb/rxr_ring_ctrl_test.sv
module rxr_ring_ctrl_test;
    localparam int TICK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frm_start = 1'b0, frm_end = 1'b0;
    logic        frm_accept, frm_drop, wb_valid, irq, ch_idle;
    logic [11:0] cur_idx, wb_index;
    logic [14:0] rb_bytes;

    int checks = 0;
    int fails  = 0;

    rxr_ring_ctrl #(.IDX_W(12), .MIN_LOG(5), .TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_start(frm_start),
        .frm_end(frm_end), .frm_accept(frm_accept), .frm_drop(frm_drop),
        .cur_idx(cur_idx), .wb_valid(wb_valid), .wb_index(wb_index), .irq(irq),
        .rb_bytes(rb_bytes), .ch_idle(ch_idle)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(int ch, int lg, int bs, int it, int tm);
        return (32'(ch) << 30) | (32'(lg) << 20) | (32'(bs) << 16) |
               (32'(it) << 12) | (32'(tm) << 4);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic start_frame(input string tag, input logic ok);
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        chk({tag, " accept"}, 32'(frm_accept), 32'(ok));
        chk({tag, " drop"}, 32'(frm_drop), 32'(!ok));
    endtask

    task automatic end_frame(input string tag, input int idx, input logic ir);
        frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        chk({tag, " wb_valid"}, 32'(wb_valid), 32'd1);
        chk({tag, " wb_index"}, 32'(wb_index), 32'(idx));
        chk({tag, " irq"}, 32'(irq), 32'(ir));
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R1: reset state
        rd(2'd0, v); chk("R1 cfg", v, 32'h0);
        rd(2'd1, v); chk("R1 wptr", v, 32'h0);
        rd(2'd2, v); chk("R1 status", v, 32'h0100_0000);
        chk("R1 pulses", {frm_accept, frm_drop, wb_valid, irq}, 32'h0);

        // R13: buffer size sweep
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, mk_cfg(0, 8, s, 0, 0));
            chk("R13 rb_bytes", 32'(rb_bytes), 32'(4096 * (s + 1)));
        end

        // R3: write index alignment rule
        for (int k = 1; k < 8; k++) begin
            wr(2'd1, 32'(k));
            rd(2'd1, v); chk("R3 misaligned ignored", v, 32'h0);
        end
        wr(2'd1, 32'd40);
        rd(2'd1, v); chk("R3 aligned stored", v, 32'd40);

        // R2 R4 R5 R6 R7: full ring sweeps, log field 0 clamps to 32 entries
        for (int pass = 0; pass < 3; pass++) begin
            int lg, sz, it;
            lg = (pass == 0) ? 0 : (pass == 1) ? 6 : 5;
            sz = (pass == 1) ? 64 : 32;
            it = (pass == 0) ? 1 : (pass == 1) ? 0 : 2;
            do_reset();
            wr(2'd0, mk_cfg(2, lg, 0, it, 0));
            start_frame("R4 empty ring full", 1'b0);
            wr(2'd1, 32'(sz - 8));
            for (int i = 0; i < sz - 8; i++) begin
                start_frame("R5 start", 1'b1);
                end_frame("R6 close", i, it == 1);
            end
            start_frame("R4 full drop", 1'b0);
            wr(2'd1, 32'd0);
            for (int i = sz - 8; i < sz; i++) begin
                start_frame("R5 start wrap", 1'b1);
                end_frame("R2 wrap close", i, it == 1);
            end
            rd(2'd2, v); chk("R2 fill wrapped", v & 32'hFFF, 32'd0);
            start_frame("R4 full after wrap", 1'b0);
        end

        // R8 R9 R14: timer
        do_reset();
        wr(2'd1, 32'd16);
        wr(2'd0, mk_cfg(2, 5, 0, 1, 3));
        frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
        chk("R14 stray end wb", 32'(wb_valid), 32'd0);
        rd(2'd2, v); chk("R14 fill unchanged", v & 32'hFFF, 32'd0);

        start_frame("R8 start", 1'b1);
        begin
            int seen = 0;
            repeat (12) begin @(negedge clk); if (wb_valid) seen++; end
            chk("R8 no early close", 32'(seen), 32'd0);
        end
        @(negedge clk);
        chk("R8 timed close", 32'(wb_valid), 32'd1);
        chk("R8 timed index", 32'(wb_index), 32'd0);

        start_frame("R9 start", 1'b1);
        repeat (12) @(negedge clk);
        end_frame("R9 coincide", 1, 1'b1);
        @(negedge clk);
        chk("R9 single close", 32'(wb_valid), 32'd0);
        rd(2'd2, v); chk("R9 fill step", v & 32'hFFF, 32'd2);

        wr(2'd0, mk_cfg(2, 5, 0, 1, 0));
        start_frame("R8 zero tmo start", 1'b1);
        begin
            int seen = 0;
            repeat (40) begin @(negedge clk); if (wb_valid) seen++; end
            chk("R8 zero tmo never closes", 32'(seen), 32'd0);
        end
        end_frame("R8 zero tmo end", 2, 1'b1);

        // R10: stop at next clock, R12: reserved value
        for (int m = 0; m < 2; m++) begin
            int chv;
            chv = (m == 0) ? 0 : 3;
            wr(2'd0, mk_cfg(2, 5, 0, 1, 0));
            start_frame("R10 start", 1'b1);
            wr(2'd0, mk_cfg(chv, 5, 0, 1, 0));
            @(negedge clk);
            rd(2'd2, v);
            chk(m == 0 ? "R10 idle" : "R12 idle", v, 32'h0100_0003);
            frm_end = 1'b1; @(negedge clk); frm_end = 1'b0;
            chk(m == 0 ? "R10 no wb" : "R12 no wb", 32'(wb_valid), 32'd0);
            start_frame(m == 0 ? "R10 start when off" : "R12 start when off", 1'b0);
        end

        // R11: pause at end of frame
        wr(2'd0, mk_cfg(2, 5, 0, 1, 0));
        start_frame("R11 start", 1'b1);
        wr(2'd0, mk_cfg(1, 5, 0, 1, 0));
        start_frame("R11 new start dropped", 1'b0);
        rd(2'd2, v); chk("R11 busy", v, 32'h0000_0003);
        end_frame("R11 frame completes", 3, 1'b1);
        rd(2'd2, v); chk("R11 idle after", v, 32'h0100_0004);
        start_frame("R11 start after pause", 1'b0);

        report();
    end
endmodule